// File: doc/BRIEF.md
# Sequential-Access Event Counter Bank

This block holds a small set of performance counters. Each counter is bound to one of 64 single-cycle event pulses by an 8-bit selector, and it adds one on every cycle where that pulse is high and counting is enabled. Software reaches the whole bank through a narrow register port. One shared item pointer decides which counter, or which 32-bit word of a counter, an access touches, and the pointer moves forward by one after every access.

A 5-bit command word resets the pointer, zeroes the counters, starts or stops counting, and copies every counter into a shadow bank at one clock edge. All readout comes from that shadow bank, so a consistent snapshot can be taken while counting goes on. A counter can be preloaded with a start value. When a counter counts up to all-ones it stays there and raises a sticky overflow flag. The interrupt output stays high until a clear command is issued. A counter preloaded close to its limit therefore produces an interrupt after a chosen number of events.

Top module: `evt_cnt_bank`

## Requirements
- R1: After reset every counter, shadow copy, overflow flag and selector is zero, the pointer is at item 0, counting is stopped, and `irq`, `dataOut` and `statOut` are 0.
- R2: A selector write stores `selData` for the counter at the pointer. Values 0 to 63 pick that bit of `evtIn`. A value of 64 or above makes the counter count nothing.
- R3: While running, a counter adds exactly one on each cycle in which its selected event bit is high. While stopped it holds its value whatever `evtIn` does.
- R4: `cmdBits` is decoded when `cmdValid` is high: bit 0 sets the pointer to 0, bit 1 clears counters and flags, bit 2 starts, bit 3 stops, bit 4 samples. Stop wins over start. Clear with start makes counting resume from zero. Every command takes effect at the next clock edge.
- R5: Each selector write, status read, data read and data write moves the pointer forward by one. After the last item it wraps to 0. A pointer reset in the same cycle wins over the step.
- R6: A sample copies every counter and its status into the shadow bank at one edge, whether the bank is running or stopped. Counting continues, and later reads return the snapshot until the next sample.
- R7: A counter wider than 32 bits takes ceil(width/32) data items, least significant word first. Data item k addresses counter k / words, word k % words. Selector and status items use item k = counter k.
- R8: A data write replaces the addressed 32-bit word of the live counter. Counting then continues from the loaded value. A clear in the same cycle wins.
- R9: A counter that counts up to all-ones stays there and sets its sticky overflow flag. `irq` is the OR of all overflow flags and returns to 0 only after a clear command.
- R10: The status item has bit 0 = overflow flag and bit 1 = full (the counter was all-ones), both captured at the sample. A counter preloaded to all-ones shows full without overflow and does not raise `irq`.
- R11: `dataOut` and `statOut` show, with no added latency, the shadow item that the current pointer addresses. `statOut` is 0 when the pointer is past the last counter. Both change only after a sample or a pointer move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 64 | Event pulses, one bit per event number |
| cmdValid | input | 1 | Command strobe |
| cmdBits | input | 5 | Command: pointer reset, clear, start, stop, sample (bits 0 to 4) |
| selWrite | input | 1 | Selector write strobe |
| selData | input | 8 | Event number for the selected counter |
| statRead | input | 1 | Status read strobe (advances pointer) |
| statOut | output | 2 | Sampled status of the item at the pointer |
| dataRead | input | 1 | Data read strobe (advances pointer) |
| dataOut | output | 32 | Sampled counter word at the pointer |
| dataWrite | input | 1 | Data write strobe (preload) |
| dataIn | input | 32 | Preload word |
| irq | output | 1 | Overflow interrupt |

## Verification
Commands, preloads and counts are registered: a strobe applied before edge N shows its effect in `dataOut`, `statOut` or `irq` just after edge N. The one exception is a count change, which only becomes visible through a later sample command. Read data is combinational from the pointer, so a read value is taken in the cycle in which the read strobe is presented, before the edge that moves the pointer. The bench drives every strobe at a falling edge, holds it for one full cycle and samples one falling edge later. This counts each register on the way: one edge for the counter, one for the sample into the shadow bank.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

  localparam int IDX_W = 8;

  // Command word, bit 4 down to bit 0
  typedef struct packed {
    logic sample;
    logic stop;
    logic start;
    logic clear;
    logic rstPtr;
  } cmd_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             clear;
    logic             sample;
    logic             run;
    logic             selWe;
    logic             preWe;
    logic [IDX_W-1:0] itemIdx;   // counter index for selector and status items
    logic [IDX_W-1:0] wordCnt;   // counter index for data items
    logic [IDX_W-1:0] wordIdx;   // word index for data items
  } strobe_t;

endpackage

// File: rtl/evt_cnt_ctrl.sv
module evt_cnt_ctrl
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CNT = 5,
  parameter int WORDS   = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [4:0]    cmdBits,
  input  logic          selWrite,
  input  logic          statRead,
  input  logic          dataRead,
  input  logic          dataWrite,
  output strobe_t       strobe
);

  localparam int ITEMS = NUM_CNT * WORDS;
  localparam int PTR_W = (ITEMS > 1) ? $clog2(ITEMS) : 1;

  cmd_t             cmd;
  logic [PTR_W-1:0] ptr;
  logic             run;
  logic             anyAccess;
  logic [IDX_W-1:0] ptrExt;

  assign cmd       = cmd_t'(cmdBits);
  assign anyAccess = selWrite | statRead | dataRead | dataWrite;
  assign ptrExt    = IDX_W'(ptr);

  // Shared item pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (cmdValid && cmd.rstPtr) begin
      ptr <= '0;
    end else if (anyAccess) begin
      if (ptr == PTR_W'(ITEMS - 1)) ptr <= '0;
      else                          ptr <= ptr + 1'b1;
    end
  end

  // Run flag; stop has priority over start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      run <= 1'b0;
    end else if (cmdValid) begin
      if (cmd.stop)       run <= 1'b0;
      else if (cmd.start) run <= 1'b1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.clear   = cmdValid & cmd.clear;
    strobe.sample  = cmdValid & cmd.sample;
    strobe.run     = run;
    strobe.selWe   = selWrite;
    strobe.preWe   = dataWrite;
    strobe.itemIdx = ptrExt;
    strobe.wordCnt = ptrExt / IDX_W'(WORDS);
    strobe.wordIdx = ptrExt % IDX_W'(WORDS);
  end

endmodule

// File: rtl/evt_cnt_dpath.sv
module evt_cnt_dpath
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CNT = 5,
  parameter int CNT_W   = 32,
  parameter int EVT_W   = 64,
  parameter int SEL_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_W-1:0] evtIn,
  input  strobe_t          strobe,
  input  logic [SEL_W-1:0] selData,
  input  logic [31:0]      dataIn,
  output logic [31:0]      dataOut,
  output logic [1:0]       statOut,
  output logic             irq
);

  localparam int WORDS  = (CNT_W + 31) / 32;
  localparam int PAD_W  = WORDS * 32;
  localparam int EVT_IW = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  logic [PAD_W-1:0] shPad  [NUM_CNT];
  logic [1:0]       shStat [NUM_CNT];
  logic [NUM_CNT-1:0] ovfVec;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] shCnt;
    logic [SEL_W-1:0] sel;
    logic             ovf;
    logic             hit;
    logic             atMax;
    logic             nearMax;
    logic             bump;
    logic             preHit;
    logic [PAD_W-1:0] padNew;

    assign hit     = (sel < SEL_W'(EVT_W)) && evtIn[sel[EVT_IW-1:0]];
    assign atMax   = &cnt;
    assign nearMax = (&cnt[CNT_W-1:1]) && !cnt[0];
    assign bump    = strobe.run && hit && !atMax;
    assign preHit  = strobe.preWe && (strobe.wordCnt == IDX_W'(i));

    always_comb begin
      padNew = PAD_W'(cnt);
      for (int w = 0; w < WORDS; w++) begin
        if (strobe.wordIdx == IDX_W'(w)) padNew[w*32 +: 32] = dataIn;
      end
    end

    // Live counter and sticky overflow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (strobe.clear) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (preHit) begin
        cnt <= padNew[CNT_W-1:0];
      end else if (bump) begin
        cnt <= cnt + 1'b1;
        if (nearMax) ovf <= 1'b1;
      end
    end

    // Event selector
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sel <= '0;
      end else if (strobe.selWe && strobe.itemIdx == IDX_W'(i)) begin
        sel <= selData;
      end
    end

    // Snapshot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shCnt     <= '0;
        shStat[i] <= '0;
      end else if (strobe.sample) begin
        shCnt     <= cnt;
        shStat[i] <= {atMax, ovf};
      end
    end

    assign shPad[i]  = PAD_W'(shCnt);
    assign ovfVec[i] = ovf;
  end

  assign irq = |ovfVec;

  always_comb begin
    dataOut = '0;
    for (int c = 0; c < NUM_CNT; c++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (strobe.wordCnt == IDX_W'(c) && strobe.wordIdx == IDX_W'(w))
          dataOut = shPad[c][w*32 +: 32];
      end
    end
  end

  always_comb begin
    statOut = '0;
    for (int c = 0; c < NUM_CNT; c++) begin
      if (strobe.itemIdx == IDX_W'(c)) statOut = shStat[c];
    end
  end

endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CNT = 5,
  parameter int CNT_W   = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] evtIn,
  input  logic        cmdValid,
  input  logic [4:0]  cmdBits,
  input  logic        selWrite,
  input  logic [7:0]  selData,
  input  logic        statRead,
  output logic [1:0]  statOut,
  input  logic        dataRead,
  output logic [31:0] dataOut,
  input  logic        dataWrite,
  input  logic [31:0] dataIn,
  output logic        irq
);

  localparam int WORDS = (CNT_W + 31) / 32;

  strobe_t strobe;
  logic    running;

  assign running = strobe.run;

  evt_cnt_ctrl #(
    .NUM_CNT (NUM_CNT),
    .WORDS   (WORDS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdBits   (cmdBits),
    .selWrite  (selWrite),
    .statRead  (statRead),
    .dataRead  (dataRead),
    .dataWrite (dataWrite),
    .strobe    (strobe)
  );

  evt_cnt_dpath #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .EVT_W   (64),
    .SEL_W   (8)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .strobe  (strobe),
    .selData (selData),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .statOut (statOut),
    .irq     (irq)
  );

endmodule

// File: rtl/evt_cnt_bank_chk.sv
module evt_cnt_bank_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [4:0]  cmdBits,
  input logic        selWrite,
  input logic        statRead,
  input logic        dataRead,
  input logic        dataWrite,
  input logic [31:0] dataOut,
  input logic [1:0]  statOut,
  input logic        irq,
  input logic        running
);

  logic anyAccess;
  assign anyAccess = selWrite | statRead | dataRead | dataWrite;

  // R9: the interrupt only falls after a clear command
  p_irq_fall_needs_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(cmdValid && cmdBits[1]));

  // R9: a clear always removes the interrupt
  p_clear_drops_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdBits[1]) |=> !irq);

  // R3: overflow can only arise while counting runs
  p_irq_rise_while_running_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(running));

  // R4: stop wins over start
  p_stop_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdBits[3]) |=> !running);

  // R4: start without stop enables counting
  p_start_runs_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdBits[2] && !cmdBits[3]) |=> running);

  // R11: readout moves only on a sample or a pointer move
  p_read_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !anyAccess) |=> ($stable(dataOut) && $stable(statOut)));

endmodule

bind evt_cnt_bank evt_cnt_bank_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdBits   (cmdBits),
  .selWrite  (selWrite),
  .statRead  (statRead),
  .dataRead  (dataRead),
  .dataWrite (dataWrite),
  .dataOut   (dataOut),
  .statOut   (statOut),
  .irq       (irq),
  .running   (running)
);

// File: tb/evt_cnt_bank_tb.sv
`timescale 1ns/1ps
module evt_cnt_bank_tb;

  localparam logic [4:0] C_RST = 5'b00001;
  localparam logic [4:0] C_CLR = 5'b00010;
  localparam logic [4:0] C_GO  = 5'b00100;
  localparam logic [4:0] C_STP = 5'b01000;
  localparam logic [4:0] C_SMP = 5'b10000;

  typedef struct packed {
    logic [7:0]  sel;
    logic [63:0] evt;
    logic [7:0]  cycles;
    logic [31:0] expect_;
  } tvec_t;

  localparam int NVEC = 6;
  localparam tvec_t VEC [NVEC] = '{
    '{sel: 8'd3,   evt: 64'h8,                  cycles: 8'd7, expect_: 32'd7},
    '{sel: 8'd63,  evt: 64'h8000_0000_0000_0000, cycles: 8'd5, expect_: 32'd5},
    '{sel: 8'd64,  evt: '1,                     cycles: 8'd4, expect_: 32'd0},
    '{sel: 8'd0,   evt: 64'h2,                  cycles: 8'd6, expect_: 32'd0},
    '{sel: 8'd200, evt: '1,                     cycles: 8'd3, expect_: 32'd0},
    '{sel: 8'd0,   evt: '1,                     cycles: 8'd9, expect_: 32'd9}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] evtIn;
  logic        cmdValid;
  logic [4:0]  cmdBits;
  logic        selWrite;
  logic [7:0]  selData;
  logic        statRead;
  logic [1:0]  statOut;
  logic        dataRead;
  logic [31:0] dataOut;
  logic        dataWrite;
  logic [31:0] dataIn;
  logic        irq;

  int nChecks = 0;
  int nErrors = 0;

  always #2 clk = ~clk;

  evt_cnt_bank #(.NUM_CNT(5), .CNT_W(48)) u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .cmdValid(cmdValid), .cmdBits(cmdBits),
    .selWrite(selWrite), .selData(selData), .statRead(statRead), .statOut(statOut),
    .dataRead(dataRead), .dataOut(dataOut), .dataWrite(dataWrite), .dataIn(dataIn),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doCmd(input logic [4:0] b);
    cmdValid = 1'b1; cmdBits = b;
    @(negedge clk);
    cmdValid = 1'b0; cmdBits = '0;
  endtask

  task automatic selW(input logic [7:0] d);
    selWrite = 1'b1; selData = d;
    @(negedge clk);
    selWrite = 1'b0;
  endtask

  task automatic dW(input logic [31:0] d);
    dataWrite = 1'b1; dataIn = d;
    @(negedge clk);
    dataWrite = 1'b0;
  endtask

  task automatic dR(output logic [31:0] v);
    v = dataOut; dataRead = 1'b1;
    @(negedge clk);
    dataRead = 1'b0;
  endtask

  task automatic sR(output logic [1:0] v);
    v = statOut; statRead = 1'b1;
    @(negedge clk);
    statRead = 1'b0;
  endtask

  task automatic pulse(input logic [63:0] p, input int n);
    evtIn = p;
    repeat (n) @(negedge clk);
    evtIn = '0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic [1:0]  s;
    logic [31:0] expMulti [10];

    rstN = 1'b0; evtIn = '0; cmdValid = 0; cmdBits = '0; selWrite = 0; selData = '0;
    statRead = 0; dataRead = 0; dataWrite = 0; dataIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 dataOut", dataOut, 0);
    check("R1 statOut", statOut, 0);
    check("R1 irq", irq, 0);
    doCmd(C_SMP);
    check("R1 sampled counter", dataOut, 0);

    // R2 / R3 / R4: table walk, each row starts with clear+start
    for (int r = 0; r < NVEC; r++) begin
      doCmd(C_RST);
      selW(VEC[r].sel);
      doCmd(C_CLR | C_GO);
      pulse(VEC[r].evt, int'(VEC[r].cycles));
      doCmd(C_STP | C_SMP | C_RST);
      dR(v);
      check($sformatf("R2 R3 R4 row %0d", r), v, VEC[r].expect_);
    end

    // R3: stopped counter holds
    pulse('1, 5);
    doCmd(C_SMP | C_RST);
    dR(v);
    check("R3 hold while stopped", v, 9);

    // R4: stop wins over start
    doCmd(C_GO | C_STP);
    pulse('1, 4);
    doCmd(C_SMP | C_RST);
    dR(v);
    check("R4 stop over start", v, 9);

    // R6: snapshot while running
    doCmd(C_CLR | C_GO);
    pulse(64'h1, 3);
    doCmd(C_SMP | C_RST);
    pulse(64'h1, 4);
    dR(v);
    check("R6 snapshot held", v, 3);
    doCmd(C_STP | C_SMP | C_RST);
    dR(v);
    check("R6 second snapshot", v, 7);

    // R5 / R7: several counters read through the shared pointer
    doCmd(C_RST);
    selW(8'd10); selW(8'd20); selW(8'd30); selW(8'd40); selW(8'd50);
    doCmd(C_CLR | C_GO);
    pulse((64'h1 << 10) | (64'h1 << 20), 2);
    pulse((64'h1 << 10) | (64'h1 << 30) | (64'h1 << 40) | (64'h1 << 50), 3);
    pulse(64'h1 << 50, 1);
    doCmd(C_STP | C_SMP | C_RST);
    expMulti = '{32'd5, 32'd0, 32'd2, 32'd0, 32'd3, 32'd0, 32'd3, 32'd0, 32'd4, 32'd0};
    for (int k = 0; k < 10; k++) begin
      dR(v);
      check($sformatf("R5 R7 item %0d", k), v, expMulti[k]);
    end
    dR(v);
    check("R5 pointer wrap", v, 5);
    doCmd(C_RST);
    for (int k = 0; k < 5; k++) begin
      sR(s);
      check($sformatf("R10 status %0d", k), s, 0);
    end
    sR(s);
    check("R11 status past last counter", s, 0);

    // R8 / R10: preload, full without overflow
    doCmd(C_RST);
    dW(32'd100); dW(32'd0); dW(32'hFFFF_FFFF); dW(32'h0000_FFFF);
    doCmd(C_SMP | C_RST);
    dR(v); check("R8 preload lo c0", v, 100);
    dR(v); check("R8 preload hi c0", v, 0);
    dR(v); check("R7 R8 preload lo c1", v, 32'hFFFF_FFFF);
    dR(v); check("R7 R8 preload hi c1", v, 32'h0000_FFFF);
    check("R10 full gives no irq", irq, 0);
    doCmd(C_RST);
    sR(s); check("R10 status c0", s, 2'b00);
    sR(s); check("R10 status full c1", s, 2'b10);
    doCmd(C_GO);
    pulse(64'h1 << 10, 2);
    doCmd(C_STP | C_SMP | C_RST);
    dR(v); check("R8 count from preload", v, 102);

    // R7: upper word write
    doCmd(C_RST);
    dW(32'd5); dW(32'h1234);
    doCmd(C_SMP | C_RST);
    dR(v); check("R7 low word", v, 5);
    dR(v); check("R7 high word", v, 32'h1234);

    // R9 / R10: overflow and interrupt
    doCmd(C_RST);
    dW(32'hFFFF_FFFE); dW(32'h0000_FFFF);
    check("R9 irq before overflow", irq, 0);
    doCmd(C_GO);
    pulse(64'h1 << 10, 3);
    check("R9 irq on overflow", irq, 1);
    doCmd(C_STP | C_SMP | C_RST);
    dR(v); check("R9 saturated lo", v, 32'hFFFF_FFFF);
    dR(v); check("R9 saturated hi", v, 32'h0000_FFFF);
    doCmd(C_RST);
    sR(s); check("R10 overflow and full", s, 2'b11);
    doCmd(C_GO);
    doCmd(C_STP);
    check("R9 irq sticky over start/stop", irq, 1);
    doCmd(C_CLR);
    check("R9 irq cleared", irq, 0);
    doCmd(C_SMP | C_RST);
    sR(s); check("R10 status after clear", s, 2'b00);

    finishRun();
  end

endmodule